// File: doc/BRIEF.md
# Host Neuron Access Command Engine

This block lets a host inspect and modify single neuron membrane potentials that are stored two per word across a set of memory banks. It takes commands from a first-word-fall-through command FIFO and returns read results through a response FIFO. Each command names a bank, a 13-bit row address and, for writes, a 36-bit signed value.

A read fetches the addressed word from the named bank and returns the selected 36-bit half, together with the bank and row taken from the command. A write fetches the word first and then writes it back. The addressed half carries the new value and the other half keeps its old content, so the neighbouring neuron in the packed word is not disturbed. The engine handles one command at a time and returns to idle after each one. It leaves the command at the head of the FIFO until the transaction is complete.

Top module: `nrn_host_access`

## Requirements
- R1: A read command (bit 53 = 0) returns in response bits 35:0 the 36-bit half of the addressed word: half [35:0] when row bit 0 is 0, half [71:36] when it is 1.
- R2: Response bits 52:49 repeat command bits 52:49 (the bank) and response bits 48:36 repeat command bits 48:36 (the row).
- R3: After a read command is accepted, the bank read is issued in the first cycle (state code 8) and the response is pushed in the second cycle (state code 9), provided the response FIFO is not full.
- R4: A write command (bit 53 = 1) reads the word in its first cycle (state code 11) and writes it back in its second cycle (state code 10). The addressed half takes command bits 35:0 and the other half keeps its previous value, including when writes to the same word follow one another.
- R5: Row bits 12:1 form the bank row address of both the read and the write. Row bit 0 selects only the half.
- R6: Only the bank whose index is in command bits 52:49 gets a read or write enable, at most one bank is enabled at a time, and a read and a write are never enabled in the same cycle.
- R7: The command FIFO read enable pulses exactly once per command, in the last cycle of its transaction, and never while the FIFO is empty. In idle with an empty FIFO, no memory enable is raised.
- R8: While the response FIFO is full, the engine stays in the read-capture state and pushes nothing. It pushes in the first cycle the FIFO is not full.
- R9: After each transaction the engine is back in idle (state code 1) in the next cycle. The state code is visible on a 4-bit debug output.
- R10: During and right after reset the engine is idle (state code 1) and raises no enable, push or pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_empty_i | input | 1 | Command FIFO empty |
| cmd_data_i | input | 54 | Head of command FIFO |
| cmd_pop_o | output | 1 | Command FIFO read enable |
| rsp_full_i | input | 1 | Response FIFO full |
| rsp_data_o | output | 53 | Response word |
| rsp_push_o | output | 1 | Response FIFO write enable |
| mem_rd_en_o | output | 16 | Per-bank read enable |
| mem_rd_addr_o | output | 192 | Per-bank read row, 12 bits each |
| mem_rd_data_i | input | 1152 | Per-bank read word, 72 bits each, one cycle after the read |
| mem_wr_en_o | output | 16 | Per-bank write enable |
| mem_wr_addr_o | output | 192 | Per-bank write row, 12 bits each |
| mem_wr_data_o | output | 1152 | Per-bank write word, 72 bits each |
| state_o | output | 4 | Engine state code |

## Verification
The assertions check a set of rules in every cycle: the one-hot enables, the rule that a read and a write never share a cycle, the rule that a write returns to the bank it just read, the fixed state order of both transaction types, and the rules that no push happens into a full response FIFO and no pop from an empty command FIFO. Only the scoreboard scenarios can show that the data is right. That covers the selected half, the echoed bank and row, the merge that keeps the neighbouring neuron, and the preservation of other banks and rows. It also covers the exact cycle of each state and push and the one-to-one count of pops against commands.

// File: rtl/nrn_host_pkg.sv
package nrn_host_pkg;
  typedef enum logic [3:0] {
    ST_IDLE     = 4'd1,
    ST_RD_ISSUE = 4'd8,
    ST_RD_CAPT  = 4'd9,
    ST_WR_MERGE = 4'd10,
    ST_WR_FETCH = 4'd11
  } eng_state_e;
endpackage

// File: rtl/nrn_cmd_fsm.sv
module nrn_cmd_fsm
  import nrn_host_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_empty_i,
  input  logic       cmd_is_wr_i,
  input  logic       rsp_full_i,
  output eng_state_e state_o,
  output logic       rd_req_o,
  output logic       wr_req_o,
  output logic       rsp_push_o,
  output logic       cmd_pop_o
);
  eng_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (!cmd_empty_i) state_d = cmd_is_wr_i ? ST_WR_FETCH : ST_RD_ISSUE;
      ST_RD_ISSUE: state_d = ST_RD_CAPT;
      ST_RD_CAPT:  if (!rsp_full_i) state_d = ST_IDLE;
      ST_WR_FETCH: state_d = ST_WR_MERGE;
      ST_WR_MERGE: state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  // re-read while stalled so the word is fresh when the push goes out
  assign rd_req_o   = (state_q == ST_RD_ISSUE) || (state_q == ST_WR_FETCH) ||
                      ((state_q == ST_RD_CAPT) && rsp_full_i);
  assign wr_req_o   = (state_q == ST_WR_MERGE);
  assign rsp_push_o = (state_q == ST_RD_CAPT) && !rsp_full_i;
  assign cmd_pop_o  = rsp_push_o || wr_req_o;
  assign state_o    = state_q;
endmodule

// File: rtl/nrn_half_merge.sv
module nrn_half_merge #(
  parameter int HALF_W = 36,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              sel_hi_i,
  input  logic [HALF_W-1:0] new_i,
  output logic [HALF_W-1:0] half_o,
  output logic [WORD_W-1:0] merged_o
);
  logic [HALF_W-1:0] lo, hi;
  assign lo = word_i[HALF_W-1:0];
  assign hi = word_i[WORD_W-1:HALF_W];

  assign half_o   = sel_hi_i ? hi : lo;
  assign merged_o = sel_hi_i ? {new_i, lo} : {hi, new_i};
endmodule

// File: rtl/nrn_bank_port.sv
module nrn_bank_port #(
  parameter int NUM_BANKS = 16,
  parameter int ADDR_W    = 12,
  parameter int WORD_W    = 72,
  localparam int GRP_W    = $clog2(NUM_BANKS)
) (
  input  logic [GRP_W-1:0]            grp_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        rd_req_i,
  input  logic                        wr_req_i,
  input  logic [WORD_W-1:0]           wdata_i,
  input  logic [NUM_BANKS*WORD_W-1:0] rdata_i,
  output logic [NUM_BANKS-1:0]        rd_en_o,
  output logic [NUM_BANKS-1:0]        wr_en_o,
  output logic [NUM_BANKS*ADDR_W-1:0] rd_addr_o,
  output logic [NUM_BANKS*ADDR_W-1:0] wr_addr_o,
  output logic [NUM_BANKS*WORD_W-1:0] wr_data_o,
  output logic [WORD_W-1:0]           rdata_sel_o
);
  logic [WORD_W-1:0] rd_words [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (grp_i == GRP_W'(b));
    assign rd_en_o[b] = hit && rd_req_i;
    assign wr_en_o[b] = hit && wr_req_i;
    assign rd_addr_o[b*ADDR_W +: ADDR_W] = addr_i;
    assign wr_addr_o[b*ADDR_W +: ADDR_W] = addr_i;
    assign wr_data_o[b*WORD_W +: WORD_W] = hit ? wdata_i : '0;
    assign rd_words[b] = rdata_i[b*WORD_W +: WORD_W];
  end

  assign rdata_sel_o = rd_words[grp_i];
endmodule

// File: rtl/nrn_host_access.sv
module nrn_host_access
  import nrn_host_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  parameter int ROW_W     = 13,
  parameter int HALF_W    = 36,
  localparam int GRP_W    = $clog2(NUM_BANKS),
  localparam int ADDR_W   = ROW_W - 1,
  localparam int WORD_W   = 2 * HALF_W,
  localparam int CMD_W    = 1 + GRP_W + ROW_W + HALF_W,
  localparam int RSP_W    = CMD_W - 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cmd_empty_i,
  input  logic [CMD_W-1:0]            cmd_data_i,
  output logic                        cmd_pop_o,
  input  logic                        rsp_full_i,
  output logic [RSP_W-1:0]            rsp_data_o,
  output logic                        rsp_push_o,
  output logic [NUM_BANKS-1:0]        mem_rd_en_o,
  output logic [NUM_BANKS*ADDR_W-1:0] mem_rd_addr_o,
  input  logic [NUM_BANKS*WORD_W-1:0] mem_rd_data_i,
  output logic [NUM_BANKS-1:0]        mem_wr_en_o,
  output logic [NUM_BANKS*ADDR_W-1:0] mem_wr_addr_o,
  output logic [NUM_BANKS*WORD_W-1:0] mem_wr_data_o,
  output logic [3:0]                  state_o
);
  // head stays stable until popped (fall-through FIFO), so fields are used directly
  logic              is_wr;
  logic [GRP_W-1:0]  grp;
  logic [ROW_W-1:0]  row;
  logic [HALF_W-1:0] wval;
  assign is_wr = cmd_data_i[CMD_W-1];
  assign grp   = cmd_data_i[CMD_W-2 -: GRP_W];
  assign row   = cmd_data_i[HALF_W +: ROW_W];
  assign wval  = cmd_data_i[HALF_W-1:0];

  eng_state_e        st;
  logic              rd_req, wr_req;
  logic [WORD_W-1:0] word_sel, word_new;
  logic [HALF_W-1:0] half_rd;

  nrn_cmd_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_empty_i (cmd_empty_i),
    .cmd_is_wr_i (is_wr),
    .rsp_full_i  (rsp_full_i),
    .state_o     (st),
    .rd_req_o    (rd_req),
    .wr_req_o    (wr_req),
    .rsp_push_o  (rsp_push_o),
    .cmd_pop_o   (cmd_pop_o)
  );

  nrn_bank_port #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W)
  ) u_banks (
    .grp_i       (grp),
    .addr_i      (row[ROW_W-1:1]),
    .rd_req_i    (rd_req),
    .wr_req_i    (wr_req),
    .wdata_i     (word_new),
    .rdata_i     (mem_rd_data_i),
    .rd_en_o     (mem_rd_en_o),
    .wr_en_o     (mem_wr_en_o),
    .rd_addr_o   (mem_rd_addr_o),
    .wr_addr_o   (mem_wr_addr_o),
    .wr_data_o   (mem_wr_data_o),
    .rdata_sel_o (word_sel)
  );

  nrn_half_merge #(.HALF_W(HALF_W)) u_merge (
    .word_i   (word_sel),
    .sel_hi_i (row[0]),
    .new_i    (wval),
    .half_o   (half_rd),
    .merged_o (word_new)
  );

  assign rsp_data_o = {grp, row, half_rd};
  assign state_o    = st;
endmodule

// File: rtl/nrn_host_access_chk.sv
module nrn_host_access_chk #(
  parameter int NUM_BANKS = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cmd_empty_i,
  input logic                 cmd_pop_o,
  input logic                 rsp_full_i,
  input logic                 rsp_push_o,
  input logic [NUM_BANKS-1:0] mem_rd_en_o,
  input logic [NUM_BANKS-1:0] mem_wr_en_o,
  input logic [3:0]           state_o
);
  p_rd_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mem_rd_en_o));
  p_wr_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mem_wr_en_o));
  p_no_rw_overlap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|mem_rd_en_o) && (|mem_wr_en_o)));
  p_wr_same_bank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|mem_wr_en_o) |-> (mem_wr_en_o == $past(mem_rd_en_o)));
  p_wr_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd11) |=> (state_o == 4'd10) && (|mem_wr_en_o));
  p_rd_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd8) |=> (state_o == 4'd9));
  p_no_push_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_push_o |-> !rsp_full_i);
  p_stall_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd9 && rsp_full_i) |=> (state_o == 4'd9));
  p_no_pop_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_pop_o |-> !cmd_empty_i);
  p_idle_after_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_pop_o |=> (state_o == 4'd1));
endmodule

bind nrn_host_access nrn_host_access_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_empty_i (cmd_empty_i),
  .cmd_pop_o   (cmd_pop_o),
  .rsp_full_i  (rsp_full_i),
  .rsp_push_o  (rsp_push_o),
  .mem_rd_en_o (mem_rd_en_o),
  .mem_wr_en_o (mem_wr_en_o),
  .state_o     (state_o)
);

// File: tb/nrn_host_access_tb_top.sv
module nrn_host_access_tb_top;
  localparam int NB = 16;
  localparam int AW = 12;
  localparam int WW = 72;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic            cmd_empty;
  logic [53:0]     cmd_data;
  logic            cmd_pop;
  logic            rsp_full = 1'b0;
  logic [52:0]     rsp_data;
  logic            rsp_push;
  logic [NB-1:0]   rd_en, wr_en;
  logic [NB*AW-1:0] rd_addr, wr_addr;
  logic [NB*WW-1:0] rd_data, wr_data;
  logic [3:0]      state;

  nrn_host_access dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_empty_i(cmd_empty), .cmd_data_i(cmd_data), .cmd_pop_o(cmd_pop),
    .rsp_full_i(rsp_full), .rsp_data_o(rsp_data), .rsp_push_o(rsp_push),
    .mem_rd_en_o(rd_en), .mem_rd_addr_o(rd_addr), .mem_rd_data_i(rd_data),
    .mem_wr_en_o(wr_en), .mem_wr_addr_o(wr_addr), .mem_wr_data_o(wr_data),
    .state_o(state)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic check(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [71:0] init_word(int b, int r);
    return {4'(b) ^ 4'hF, 12'(r), 20'hC3A5E, 4'(b), 12'(r), 20'h3C5A1};
  endfunction

  // bank memory model, sparse
  logic [71:0] mem_m [int];
  logic [71:0] rd_q [NB];
  function automatic logic [71:0] mem_get(int b, int r);
    int k = b * 4096 + r;
    return mem_m.exists(k) ? mem_m[k] : init_word(b, r);
  endfunction

  always @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (wr_en[b]) mem_m[b * 4096 + int'(wr_addr[b*AW +: AW])] = wr_data[b*WW +: WW];
      if (rd_en[b]) rd_q[b] <= mem_get(b, int'(rd_addr[b*AW +: AW]));
    end
  end
  always_comb for (int b = 0; b < NB; b++) rd_data[b*WW +: WW] = rd_q[b];

  // reference model, independent of the memory model
  logic [71:0] ref_m [int];
  function automatic logic [71:0] ref_get(int b, int r);
    int k = b * 4096 + r;
    return ref_m.exists(k) ? ref_m[k] : init_word(b, r);
  endfunction

  // fall-through command FIFO
  logic [53:0] cf_mem [64];
  logic [5:0]  cf_head = '0, cf_tail = '0;
  assign cmd_empty = (cf_head == cf_tail);
  assign cmd_data  = cf_mem[cf_head];
  always @(posedge clk) if (cmd_pop) cf_head <= cf_head + 6'd1;

  // response FIFO full pattern
  logic        force_full = 1'b0, rand_full = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  always @(posedge clk) begin
    lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rsp_full <= force_full | (rand_full & lfsr[0] & lfsr[3]);
  end

  logic [52:0] exp_q [$];
  int n_sent = 0, n_pops = 0, bad_en = 0;

  task automatic send(input bit wr, input int b, input int row, input logic [35:0] d);
    logic [71:0] w;
    int r12;
    while (cf_tail + 6'd1 == cf_head) @(negedge clk);
    r12 = row >> 1;
    w = ref_get(b, r12);
    if (wr) begin
      if (row[0]) w[71:36] = d; else w[35:0] = d;
      ref_m[b * 4096 + r12] = w;
    end else begin
      exp_q.push_back({4'(b), 13'(row), row[0] ? w[71:36] : w[35:0]});
    end
    cf_mem[cf_tail] = {wr, 4'(b), 13'(row), d};
    cf_tail = cf_tail + 6'd1;
    n_sent++;
  endtask

  // scoreboard monitor and per-cycle observations
  always @(negedge clk) if (rst_n) begin
    if (cmd_pop) n_pops++;
    if ($countones(rd_en) > 1 || $countones(wr_en) > 1) bad_en++;
    if (|rd_en && !cmd_empty && rd_en != (NB'(1) << cmd_data[52:49])) bad_en++;
    if (|wr_en && !cmd_empty && wr_en != (NB'(1) << cmd_data[52:49])) bad_en++;
    if (rsp_push) begin
      if (exp_q.size() == 0) check(1'b0, "R1 unexpected response", 72'(rsp_data), 72'(0));
      else begin
        logic [52:0] e;
        e = exp_q.pop_front();
        check(rsp_data[35:0] == e[35:0], "R1 read half", 72'(rsp_data[35:0]), 72'(e[35:0]));
        check(rsp_data[52:36] == e[52:36], "R2 echo bank/row", 72'(rsp_data[52:36]), 72'(e[52:36]));
      end
    end
  end

  task automatic drain();
    int g = 0;
    while (!(cmd_empty && state == 4'd1 && exp_q.size() == 0) && g < 5000) begin
      @(negedge clk); g++;
    end
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(state == 4'd1, "R10 state in reset", 72'(state), 72'd1);
    check(rd_en == '0 && wr_en == '0, "R10 enables in reset", 72'({rd_en, wr_en}), 72'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(state == 4'd1 && !cmd_pop && !rsp_push, "R10 idle after reset", 72'(state), 72'd1);

    // R7 empty FIFO: nothing happens
    repeat (4) @(negedge clk);
    check(state == 4'd1 && rd_en == '0 && wr_en == '0 && n_pops == 0, "R7 idle when empty",
          72'({state, rd_en}), 72'h10000);

    // R3 read timing, bank 3 row 5 (upper half, row addr 2)
    send(1'b0, 3, 5, '0);
    @(negedge clk);
    check(state == 4'd8, "R3 read issue state", 72'(state), 72'd8);
    check(rd_en == 16'h0008, "R6 read bank enable", 72'(rd_en), 72'h8);
    check(rd_addr[3*AW +: AW] == 12'd2, "R5 read row address", 72'(rd_addr[3*AW +: AW]), 72'd2);
    @(negedge clk);
    check(state == 4'd9 && rsp_push, "R3 push in capture", 72'({state, rsp_push}), 72'h13);
    check(cmd_pop, "R7 pop at end of read", 72'(cmd_pop), 72'd1);
    @(negedge clk);
    check(state == 4'd1, "R9 back to idle", 72'(state), 72'd1);

    // R4 write, bank 7 row 9 -> upper half, row addr 4
    send(1'b1, 7, 9, 36'h8_0000_0001);
    @(negedge clk);
    check(state == 4'd11 && rd_en == 16'h0080, "R4 write fetch", 72'({state, rd_en}), 72'hB0080);
    check(!cmd_pop, "R7 no pop mid write", 72'(cmd_pop), 72'd0);
    @(negedge clk);
    check(state == 4'd10 && wr_en == 16'h0080, "R4 write back", 72'({state, wr_en}), 72'hA0080);
    check(wr_addr[7*AW +: AW] == 12'd4, "R5 write row address", 72'(wr_addr[7*AW +: AW]), 72'd4);
    check(wr_data[7*WW +: WW] == {36'h8_0000_0001, init_word(7, 4)[35:0]}, "R4 merged word",
          wr_data[7*WW +: WW], {36'h8_0000_0001, init_word(7, 4)[35:0]});
    check(cmd_pop, "R7 pop at end of write", 72'(cmd_pop), 72'd1);
    send(1'b0, 7, 9, '0);   // R1 new upper
    send(1'b0, 7, 8, '0);   // R4 lower preserved
    send(1'b0, 6, 9, '0);   // R6 other bank untouched
    drain();

    // R8 stall while response FIFO is full
    force_full = 1'b1;
    @(negedge clk);
    send(1'b0, 12, 100, '0);
    repeat (6) @(negedge clk);
    check(state == 4'd9 && !rsp_push && !cmd_pop, "R8 hold while full",
          72'({state, rsp_push, cmd_pop}), 72'h24);
    force_full = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R8 push after release", 72'(exp_q.size()), 72'd0);
    drain();

    // R4 back-to-back writes to both halves of one word, then reads
    send(1'b1, 0, 40, 36'h1_2345_6789);
    send(1'b1, 0, 41, 36'hF_EDCB_A987);
    send(1'b1, 0, 40, 36'h0_0000_0055);
    send(1'b0, 0, 40, '0);
    send(1'b0, 0, 41, '0);
    drain();

    // scoreboard burst with random full, small row set to collide
    rand_full = 1'b1;
    for (int i = 0; i < 300; i++) begin
      bit          wr = 1'($urandom_range(0, 1));
      int          b  = $urandom_range(0, NB - 1);
      int          r  = $urandom_range(0, 7);
      logic [35:0] d  = {4'($urandom), 32'($urandom)};
      send(wr, b, r, d);
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end
    for (int b = 0; b < NB; b++) for (int r = 0; r < 8; r++) send(1'b0, b, r, '0);
    drain();
    rand_full = 1'b0;
    drain();

    check(n_pops == n_sent, "R7 one pop per command", 72'(n_pops), 72'(n_sent));
    check(bad_en == 0, "R6 bank enables", 72'(bad_en), 72'd0);
    check(exp_q.size() == 0 && state == 4'd1, "R9 drained to idle", 72'(exp_q.size()), 72'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule